// File: doc/BRIEF.md
# Two-Input Equality Run Detector

The block watches two single-bit streams sampled on the same clock. It reports when they have agreed for four consecutive cycles. It keeps a saturating count of how many cycles in a row the streams have been equal before the present one. The output rises in the very cycle that makes the fourth agreement, and it stays high for every further agreeing cycle, because runs overlap and the count does not restart after a hit. The first cycle of disagreement drops the output in that same cycle and clears the count.

The default output is Mealy-type: a combinational function of the stored count and the present inputs. Downstream logic on the same clock can sample it directly. A consumer in another timing domain should set the parameter `REG_OUT` to 1. In that mode the output is taken from a flip-flop that holds the value the combinational output had in the previous cycle, so it changes only just after a rising edge. The reset is synchronous and active low.

Top module: `eq_run_detector`

## Requirements
- R1: With REG_OUT=0, `run_hit` is 1 in the same cycle as the fourth consecutive cycle with `stream_a == stream_b`, with no extra cycle of delay.
- R2: After a run of four equal cycles, `run_hit` stays 1 in every further consecutive cycle where the streams are equal.
- R3: In any cycle where `stream_a != stream_b`, `run_hit` is 0 in that cycle. That cycle also restarts the run, so four new equal cycles are needed before the next 1.
- R4: While the current run of equal cycles, counting the present one, is shorter than four, `run_hit` is 0.
- R5: A reset is applied when `rst_n` is 0 at a rising edge, and it clears the run count. In a cycle where `rst_n` is 0, the Mealy output is 0. After release, four new equal cycles are needed before `run_hit` returns to 1.
- R6: With REG_OUT=1, `run_hit` after each rising edge equals the Mealy output of the cycle just before that edge. If `rst_n` was 0 at that edge, it is 0. It does not change between edges.
- R7: For stream_a = 0,1,1,0,1,1,1,0,0,0,1,1,0 and stream_b = 1,1,1,0,1,0,1,0,0,0,1,1,1, applied after reset, the Mealy output is 0,0,0,0,1,0,0,0,0,1,1,1,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stream_a | input | 1 | First compared stream |
| stream_b | input | 1 | Second compared stream |
| run_hit | output | 1 | High while four or more consecutive cycles have had equal streams |

## Verification
The only internal state is the saturating run count. If the count is wrong, the output reports a wrong value within at most four cycles of agreeing inputs: an early hit after three agreements, a late hit after five, or a missed hold while the streams stay equal. The bench therefore compares both output modes, every cycle, against a model that keeps the last four equality results. It uses long runs of biased random stimulus, runs of exact length three and four, mismatches and resets that arrive mid-run, so a stray count value reaches the ports within a few cycles.

// File: rtl/eq_run_pkg.sv
package eq_run_pkg;
    localparam int RUN_LEN = 4;
    localparam int CNT_W   = $clog2(RUN_LEN);

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_SAT = cnt_t'(RUN_LEN - 1);

    typedef struct packed {
        cnt_t cnt;
    } ctr_state_t;

    typedef struct packed {
        logic hit;
    } out_state_t;
endpackage

// File: rtl/eq_run_counter.sv
module eq_run_counter
    import eq_run_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic hit_o,
    output cnt_t cnt_o
);
    ctr_state_t st_d, st_q;
    logic       same;

    always_comb begin
        same = ~(in_a ^ in_b);
        st_d = st_q;
        if (!rst_n) begin
            st_d.cnt = '0;
        end else if (!same) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_SAT) begin
            st_d.cnt = st_q.cnt + cnt_t'(1);
        end
        hit_o = rst_n & same & (st_q.cnt == CNT_SAT);
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R5
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> st_q.cnt == '0);

    // R3
    mismatch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a != in_b) |=> st_q.cnt == '0);

    // R2
    saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a == in_b) && (st_q.cnt == CNT_SAT) |=> st_q.cnt == CNT_SAT);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a == in_b) && (st_q.cnt != CNT_SAT) |=> st_q.cnt == $past(st_q.cnt) + cnt_t'(1));
endmodule

// File: rtl/eq_run_outstage.sv
module eq_run_outstage
    import eq_run_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic hit_o
);
    generate
        if (REG_OUT) begin : g_reg
            out_state_t out_d, out_q;

            always_comb begin
                out_d     = out_q;
                out_d.hit = rst_n ? hit_i : 1'b0;
            end

            always_ff @(posedge clk) begin
                out_q <= out_d;
            end

            assign hit_o = out_q.hit;

            // R6
            reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> hit_o == $past(hit_i));
        end else begin : g_comb
            assign hit_o = hit_i;
        end
    endgenerate
endmodule

// File: rtl/eq_run_detector.sv
module eq_run_detector
    import eq_run_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stream_a,
    input  logic stream_b,
    output logic run_hit
);
    logic mealy_hit;
    cnt_t run_cnt;

    eq_run_counter u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .in_a  (stream_a),
        .in_b  (stream_b),
        .hit_o (mealy_hit),
        .cnt_o (run_cnt)
    );

    eq_run_outstage #(.REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (mealy_hit),
        .hit_o (run_hit)
    );

    // R3
    mismatch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_a != stream_b) |-> !mealy_hit);

    // R1
    fourth_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_a == stream_b) && (run_cnt == CNT_SAT) |-> mealy_hit);
endmodule

// File: tb/test_eq_run_detector.sv
`timescale 1ns/1ps
module test_eq_run_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sa = 1'b0;
    logic sb = 1'b0;
    logic hit_m, hit_r;

    always #2.5 clk = ~clk;

    eq_run_detector #(.REG_OUT(1'b0)) i_eq_run_detector (
        .clk(clk), .rst_n(rst_n), .stream_a(sa), .stream_b(sb), .run_hit(hit_m));

    eq_run_detector #(.REG_OUT(1'b1)) i_eq_run_detector_reg (
        .clk(clk), .rst_n(rst_n), .stream_a(sa), .stream_b(sb), .run_hit(hit_r));

    bit    exp_m_q[$];
    bit    exp_r_q[$];
    string tag_m_q[$];
    string tag_r_q[$];

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    bit [3:0] hist = 4'b0;
    bit       reg_model = 1'b0;

    task automatic drive(input bit a, input bit b, input bit rst_low, input string force_tag);
        bit    eq;
        bit    em;
        string tg;
        @(negedge clk);
        sa    = a;
        sb    = b;
        rst_n = ~rst_low;
        eq    = (a == b);
        em    = !rst_low && eq && (&hist[2:0]);
        if (rst_low)               tg = "R5";
        else if (!eq)              tg = "R3";
        else if (&hist[2:0])       tg = hist[3] ? "R2" : "R1";
        else                       tg = "R4";
        if (force_tag != "") tg = force_tag;
        exp_m_q.push_back(em);
        tag_m_q.push_back(tg);
        exp_r_q.push_back(reg_model);
        tag_r_q.push_back("R6");
        reg_model = rst_low ? 1'b0 : em;
        hist      = rst_low ? 4'b0 : {hist[2:0], eq};
    endtask

    always @(negedge clk) begin
        #1;
        if (exp_m_q.size() > 0) begin
            bit    em, er;
            string tm, tr;
            em = exp_m_q.pop_front();
            er = exp_r_q.pop_front();
            tm = tag_m_q.pop_front();
            tr = tag_r_q.pop_front();
            n_checks += 2;
            if (hit_m !== em) begin
                n_fail++;
                $display("FAIL %s mealy output actual=%b expected=%b at %0t", tm, hit_m, em, $time);
            end
            if (hit_r !== er) begin
                n_fail++;
                $display("FAIL %s registered output actual=%b expected=%b at %0t", tr, hit_r, er, $time);
            end
        end
    end

    initial begin
        bit [12:0] wa = 13'b0110111000110;
        bit [12:0] wb = 13'b1110101000111;
        repeat (3) begin
            @(negedge clk);
            rst_n = 1'b0;
        end
        hist = 4'b0;
        reg_model = 1'b0;
        drive(1'b1, 1'b1, 1'b1, "R5");
        // R7: stated waveform, MSB first
        for (int i = 12; i >= 0; i--) drive(wa[i], wb[i], 1'b0, "R7");
        // R4/R1: exactly three matches then a break, then exactly four
        drive(1'b0, 1'b1, 1'b0, "");
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 1'b0, "");
        drive(1'b1, 1'b0, 1'b0, "");
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b0, "");
        // R2: long overlapping run
        for (int i = 0; i < 8; i++) drive(i[0], i[0], 1'b0, "");
        // R5: reset in the middle of a saturated run
        drive(1'b1, 1'b1, 1'b1, "");
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, 1'b0, "");
        // random traffic biased toward equality, with occasional resets
        for (int i = 0; i < 4000; i++) begin
            bit a, b, r;
            a = 1'($urandom);
            b = (($urandom % 5) == 0) ? ~a : a;
            r = (($urandom % 150) == 0);
            drive(a, b, r, "");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule